// File: doc/BRIEF.md
# Balanced Four-Rail Codeword Logic Unit

This unit works on codewords in which every data bit is carried as a 4-bit group of Hamming weight two. A codeword of `NBITS` data bits is therefore `4*NBITS` bits wide. Each group follows one of three encoding types, so the same data can be held in three interchangeable forms.

The unit accepts one operation per handshake. It can turn a plain byte into a codeword of a chosen type and turn a codeword back into plain data. It can also change a codeword's type, and it computes XOR, NOT and AND directly on codewords. AND is built from a fixed chain of masked AND, OR and XOR steps over the whole word, with no table and no memory.

Results are held in one output register, which also keeps a type tag, until the consumer takes them. Each data bit passes through the logic as a weight-2 group. The result register always holds a balanced word, so the number of ones it contains does not depend on the data.

Top module: `balcode_alu`

## Requirements
- R1: After reset `res_word` holds the type-1 encoding of all-zero data (every group 1010), `res_type` is 1, `plain_out` is 0, and `out_valid`, `reject` and `bad_group` are 0.
- R2: Encoding (op 0) maps data bit i to group `[4i+3:4i]`. Bit 0 becomes 1010, 1100 or 0110 and bit 1 becomes 0101, 0011 or 1001 for types 1, 2 and 3 respectively. The result is tagged with `want_type`.
- R3: Decoding (op 1) recovers the data of `a_word` under `a_type` into `plain_out`. If any group is not one of the two legal patterns of that type, `bad_group` is raised and `plain_out`, `res_word` and `res_type` keep their values.
- R4: Conversion (op 2) re-encodes the data of `a_word` from `a_type` into `want_type` and sets `res_type` to `want_type`.
- R5: XOR (op 3) of operands of two different types yields the XOR of their data, encoded in the third type (1 and 2 give 3, 1 and 3 give 2, 2 and 3 give 1).
- R6: NOT (op 4) yields the bitwise inverse of `a_word`. This encodes the inverted data in the same type.
- R7: AND (op 5) takes `a_word` as type 1 and `b_word` as type 2 and yields the AND of their data as type 1.
- R8: A type tag of 0 where a type is needed, equal types for XOR, any tag pair other than (1,2) for AND, or an opcode of 6 or 7 sets `reject`. `res_word`, `res_type` and `plain_out` then keep their previous values. A legal operation clears `reject`.
- R9: Every 4-bit group of `res_word` has Hamming weight 2 on every cycle.
- R10: `in_ready` equals `!out_valid || out_ready`. Each accepted operation raises `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| op | input | 3 | 0 encode, 1 decode, 2 convert, 3 XOR, 4 NOT, 5 AND |
| a_word | input | 4*NBITS | First codeword operand |
| a_type | input | 2 | Type tag of `a_word` (1..3) |
| b_word | input | 4*NBITS | Second codeword operand |
| b_type | input | 2 | Type tag of `b_word` (1..3) |
| plain_in | input | NBITS | Plain data for encoding |
| want_type | input | 2 | Target type for encode and convert |
| out_valid | output | 1 | Result register holds a fresh result |
| out_ready | input | 1 | Consumer takes the result |
| res_word | output | 4*NBITS | Result codeword |
| res_type | output | 2 | Type tag of `res_word` |
| plain_out | output | NBITS | Data recovered by the last good decode |
| reject | output | 1 | Last operation refused |
| bad_group | output | 1 | Last decode met an illegal group |

## Verification
The bench builds the unit with the default `NBITS` of 8, which gives full 32-bit codewords. With this width every type pair for XOR, both tag orders for AND and each single-group corruption during decode can be reached with bytes whose data bits mix ones and zeros. The reference model works only from the pattern table in the requirements. It holds `out_ready` low across several offered operations to exercise the stall path.

// File: rtl/balcode_alu.sv
module balcode_alu #(
  parameter int NBITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         op,
  input  logic [NBITS*4-1:0] a_word,
  input  logic [1:0]         a_type,
  input  logic [NBITS*4-1:0] b_word,
  input  logic [1:0]         b_type,
  input  logic [NBITS-1:0]   plain_in,
  input  logic [1:0]         want_type,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [NBITS*4-1:0] res_word,
  output logic [1:0]         res_type,
  output logic [NBITS-1:0]   plain_out,
  output logic               reject,
  output logic               bad_group
);
  localparam int W = NBITS * 4;
  localparam logic [W-1:0] FILL_0011 = {NBITS{4'b0011}};
  localparam logic [W-1:0] FILL_1010 = {NBITS{4'b1010}};
  localparam logic [W-1:0] FILL_0001 = {NBITS{4'b0001}};
  localparam logic [2:0] OP_ENC = 3'd0, OP_DEC = 3'd1, OP_CONV = 3'd2,
                         OP_XOR = 3'd3, OP_NOT = 3'd4, OP_AND = 3'd5;

  function automatic logic [3:0] tmask(input logic [1:0] t);
    case (t)
      2'd2:    tmask = 4'b0110;
      2'd3:    tmask = 4'b1100;
      default: tmask = 4'b0000;
    endcase
  endfunction

  logic [W-1:0]     enc_w, conv_w, and_w, next_word;
  logic [NBITS-1:0] dec_bits, grp_ok;
  logic [1:0]       next_type;
  logic             ok, upd_word, upd_plain, accept, a_ok, b_ok, w_ok;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign a_ok     = a_type != 2'd0;
  assign b_ok     = b_type != 2'd0;
  assign w_ok     = want_type != 2'd0;

  for (genvar i = 0; i < NBITS; i++) begin : g_grp
    logic [3:0] norm;
    assign norm              = a_word[4*i +: 4] ^ tmask(a_type);
    assign enc_w[4*i +: 4]   = (plain_in[i] ? 4'b0101 : 4'b1010) ^ tmask(want_type);
    assign conv_w[4*i +: 4]  = norm ^ tmask(want_type);
    assign dec_bits[i]       = norm == 4'b0101;
    assign grp_ok[i]         = (norm == 4'b0101) || (norm == 4'b1010);

    p_group_weight_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(res_word[4*i +: 4]) == 2);
  end

  assign and_w = (a_word & b_word) ^ (a_word | FILL_0011)
               ^ ((b_word & FILL_1010) | FILL_0001);

  always_comb begin
    ok        = 1'b0;
    upd_word  = 1'b0;
    upd_plain = 1'b0;
    next_word = res_word;
    next_type = res_type;
    case (op)
      OP_ENC:  begin ok = w_ok; upd_word = 1'b1; next_word = enc_w; next_type = want_type; end
      OP_DEC:  begin ok = a_ok; upd_plain = &grp_ok; end
      OP_CONV: begin ok = a_ok && w_ok; upd_word = 1'b1; next_word = conv_w; next_type = want_type; end
      OP_XOR:  begin ok = a_ok && b_ok && (a_type != b_type); upd_word = 1'b1;
                     next_word = a_word ^ b_word; next_type = a_type ^ b_type; end
      OP_NOT:  begin ok = a_ok; upd_word = 1'b1; next_word = ~a_word; next_type = a_type; end
      OP_AND:  begin ok = (a_type == 2'd1) && (b_type == 2'd2); upd_word = 1'b1;
                     next_word = and_w; next_type = 2'd1; end
      default: ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_word  <= FILL_1010;
      res_type  <= 2'd1;
      plain_out <= '0;
      reject    <= 1'b0;
      bad_group <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      reject    <= !ok;
      bad_group <= ok && (op == OP_DEC) && !(&grp_ok);
      if (ok && upd_word) begin
        res_word <= next_word;
        res_type <= next_type;
      end
      if (ok && upd_plain) plain_out <= dec_bits;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_type_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_type != 2'd0);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_word) && $stable(res_type)
                                && $stable(plain_out) && $stable(reject));
  p_reject_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !ok |=> reject && $stable(res_word) && $stable(res_type) && $stable(plain_out));
  p_bad_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_DEC && a_ok && !(&grp_ok) |=> bad_group && $stable(plain_out)
                                                    && $stable(res_word));
  p_and_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_AND && ok |=> res_type == 2'd1);
  p_xor_third_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_XOR && ok |=> res_type == $past(a_type ^ b_type));
endmodule

// File: tb/test_balcode_alu.sv
module test_balcode_alu;
  localparam int NB = 8;
  localparam int W  = NB * 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [2:0] op = '0;
  logic [W-1:0] a_word = '0, b_word = '0;
  logic [1:0] a_type = 2'd1, b_type = 2'd1, want_type = 2'd1;
  logic [NB-1:0] plain_in = '0;
  logic in_ready, out_valid, reject, bad_group;
  logic [W-1:0] res_word;
  logic [1:0] res_type;
  logic [NB-1:0] plain_out;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  balcode_alu #(.NBITS(NB)) i_balcode_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .op(op),
    .a_word(a_word), .a_type(a_type), .b_word(b_word), .b_type(b_type),
    .plain_in(plain_in), .want_type(want_type), .out_valid(out_valid),
    .out_ready(out_ready), .res_word(res_word), .res_type(res_type),
    .plain_out(plain_out), .reject(reject), .bad_group(bad_group));

  always #5 clk = ~clk;

  function automatic logic [3:0] pat(int t, bit v);
    case (t)
      1: return v ? 4'b0101 : 4'b1010;
      2: return v ? 4'b0011 : 4'b1100;
      default: return v ? 4'b1001 : 4'b0110;
    endcase
  endfunction

  function automatic logic [W-1:0] enc(logic [NB-1:0] d, int t);
    logic [W-1:0] w;
    for (int i = 0; i < NB; i++) w[4*i +: 4] = pat(t, d[i]);
    return w;
  endfunction

  function automatic bit dec(logic [W-1:0] w, int t, output logic [NB-1:0] d);
    bit good = 1'b1;
    d = '0;
    for (int i = 0; i < NB; i++) begin
      if (w[4*i +: 4] == pat(t, 1'b1)) d[i] = 1'b1;
      else if (w[4*i +: 4] != pat(t, 1'b0)) good = 1'b0;
    end
    return good;
  endfunction

  // reference model state
  logic m_valid, m_rej, m_bad;
  logic [W-1:0] m_word;
  logic [1:0] m_type;
  logic [NB-1:0] m_plain;
  string m_req = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0; m_rej <= 1'b0; m_bad <= 1'b0;
      m_word <= enc('0, 1); m_type <= 2'd1; m_plain <= '0; m_req <= "R1";
    end else if (in_valid && (!m_valid || out_ready)) begin
      automatic logic [NB-1:0] da, db, dd;
      automatic int ta = a_type, tb = b_type, tw = want_type;
      automatic bit lg;
      void'(dec(a_word, ta, da));
      void'(dec(b_word, tb, db));
      m_valid <= 1'b1;
      m_bad   <= 1'b0;
      m_rej   <= 1'b1;
      m_req   <= "R8";
      case (op)
        3'd0: if (tw != 0) begin
          m_rej <= 1'b0; m_req <= "R2"; m_word <= enc(plain_in, tw); m_type <= want_type;
        end
        3'd1: if (ta != 0) begin
          m_rej <= 1'b0; m_req <= "R3";
          lg = dec(a_word, ta, dd);
          if (lg) m_plain <= dd; else m_bad <= 1'b1;
        end
        3'd2: if (ta != 0 && tw != 0) begin
          m_rej <= 1'b0; m_req <= "R4"; m_word <= enc(da, tw); m_type <= want_type;
        end
        3'd3: if (ta != 0 && tb != 0 && ta != tb) begin
          m_rej <= 1'b0; m_req <= "R5"; m_word <= enc(da ^ db, 6 - ta - tb);
          m_type <= 2'(6 - ta - tb);
        end
        3'd4: if (ta != 0) begin
          m_rej <= 1'b0; m_req <= "R6"; m_word <= enc(~da, ta); m_type <= a_type;
        end
        3'd5: if (ta == 1 && tb == 2) begin
          m_rej <= 1'b0; m_req <= "R7"; m_word <= enc(da & db, 1); m_type <= 2'd1;
        end
        default: ;
      endcase
    end else if (out_ready) begin
      m_valid <= 1'b0;
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(m_req, "res_word", 64'(res_word), 64'(m_word));
      chk(m_req, "res_type", 64'(res_type), 64'(m_type));
      chk(m_req, "plain_out", 64'(plain_out), 64'(m_plain));
      chk("R8", "reject", 64'(reject), 64'(m_rej));
      chk("R3", "bad_group", 64'(bad_group), 64'(m_bad));
      chk("R10", "out_valid", 64'(out_valid), 64'(m_valid));
      chk("R10", "in_ready", 64'(in_ready), 64'(!m_valid || out_ready));
      for (int i = 0; i < NB; i++)
        chk("R9", "group weight", 64'($countones(res_word[4*i +: 4])), 64'd2);
    end
  end

  task automatic send(logic [2:0] o, logic [W-1:0] a, logic [1:0] ta, logic [W-1:0] b,
                      logic [1:0] tb, logic [NB-1:0] p, logic [1:0] tw);
    @(negedge clk);
    op = o; a_word = a; a_type = ta; b_word = b; b_type = tb; plain_in = p; want_type = tw;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_vec++; n_bad++;
    $display("FAIL watchdog expired: actual running expected finished");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    automatic logic [NB-1:0] bytes [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81, 8'h6E};
    automatic logic [W-1:0] bad_w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk("R1", "reset res_word", 64'(res_word), 64'({NB{4'b1010}}));
    chk("R1", "reset res_type", 64'(res_type), 64'd1);
    chk("R1", "reset out_valid", 64'(out_valid), 64'd0);
    chk("R1", "reset flags", 64'({reject, bad_group}), 64'd0);
    // R2 encode a known byte into type 3, checked against the pattern list
    send(3'd0, '0, 2'd1, '0, 2'd1, 8'h01, 2'd3);
    chk("R2", "encode 01 type3", 64'(res_word), 64'({{7{4'b0110}}, 4'b1001}));
    foreach (bytes[x]) begin
      for (int t = 1; t <= 3; t++) begin
        send(3'd0, '0, 2'd1, '0, 2'd1, bytes[x], 2'(t));                       // R2
        send(3'd1, enc(bytes[x], t), 2'(t), '0, 2'd1, '0, 2'd1);               // R3
        send(3'd4, enc(bytes[x], t), 2'(t), '0, 2'd1, '0, 2'd1);               // R6
        for (int u = 1; u <= 3; u++) begin
          send(3'd2, enc(bytes[x], t), 2'(t), '0, 2'd1, '0, 2'(u));            // R4
          send(3'd3, enc(bytes[x], t), 2'(t), enc(bytes[(x + 1) % 6], u), 2'(u), '0, 2'd1); // R5, R8 same type
          send(3'd5, enc(bytes[x], t), 2'(t), enc(bytes[(x + 2) % 6], u), 2'(u), '0, 2'd1); // R7, R8 wrong tags
        end
      end
    end
    // R3 illegal group in each position, each type
    for (int t = 1; t <= 3; t++) begin
      for (int g = 0; g < NB; g++) begin
        send(3'd1, enc(8'h5A, t), 2'(t), '0, 2'd1, '0, 2'd1);
        bad_w = enc(8'h5A, t);
        bad_w[4*g +: 4] = (g % 2 == 0) ? 4'b1111 : 4'b0000;
        send(3'd1, bad_w, 2'(t), '0, 2'd1, '0, 2'd1);
      end
    end
    // R8 zero tags and unused opcodes
    send(3'd0, '0, 2'd1, '0, 2'd1, 8'h77, 2'd0);
    send(3'd1, enc(8'h12, 1), 2'd0, '0, 2'd1, '0, 2'd1);
    send(3'd4, enc(8'h12, 1), 2'd0, '0, 2'd1, '0, 2'd1);
    send(3'd6, enc(8'h12, 1), 2'd1, enc(8'h34, 2), 2'd2, 8'h12, 2'd2);
    send(3'd7, enc(8'h12, 1), 2'd1, enc(8'h34, 2), 2'd2, 8'h12, 2'd2);
    // R10 stall: consumer not ready while new work is offered
    @(negedge clk);
    out_ready = 1'b0;
    send(3'd0, '0, 2'd1, '0, 2'd1, 8'hC3, 2'd2);
    send(3'd0, '0, 2'd1, '0, 2'd1, 8'h3C, 2'd3);
    @(negedge clk);
    op = 3'd4; a_word = enc(8'h0F, 1); a_type = 2'd1; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule